// File: doc/BRIEF.md
# Multi-Lane Serial Audio Transmitter

This block turns parallel audio frames into serial bit streams on up to four data lanes, using the standard I2S word-select framing. Each lane carries one stereo channel pair. A frame holds every channel of one sampling instant. It arrives through a valid/ready stream, and the block pulls it at the start of each left/right slot pair.

The block runs in one of two modes. In master mode it makes the bit clock from an integer divider of the system clock and drives word select. In slave mode it follows an external bit clock and word select. The following can change at run time while the engine is stopped:

- the justification format: standard, left-justified or right-justified;
- the slot width and the sample size;
- the number of active lanes and channels;
- a loopback path that feeds the transmit lanes back into the receive inputs.

Top module: `i2s_mlane_tx`

## Requirements
- R1: `cfg_align` selects the format. Code 0 is standard: the MSB is one bit clock after the word-select change. Code 1 is left-justified: the MSB is in the first bit of the slot. Code 2 is right-justified: the LSB is in the last bit of the slot.
- R2: With `cfg_master`=1, `bclk_o` idles high and toggles every `cfg_div_m1`+1 clocks, so its period is 2·(`cfg_div_m1`+1) clocks. `ws_o` and `sd_o` change only on its falling edges. `ws_o` is 0 during the left slot and 1 during the right slot.
- R3: `cfg_slot_m1` and `cfg_size_m1` hold the slot width and the sample size minus one. A slot is `cfg_slot_m1`+1 bit clocks long. Bits of a slot that are not sample bits are driven 0.
- R4: Lane l carries channel 2l in the left slot and channel 2l+1 in the right slot. A lane above `cfg_lanes_m1`, and a channel above `cfg_chans_m1`, sends zeros.
- R5: With `cfg_chans_m1`=0 (mono), channel 0 goes out on lane 0 in the left slot, and the right slot is all zeros.
- R6: `s_ready` is high for exactly one clock at each frame start, which is the falling bit-clock edge that opens a left slot. Channel c is taken from `s_data[32c+31:32c]`, and its sample is the low bits of that field.
- R7: If `s_valid` is low at a frame start, the whole frame is sent as zeros and `underrun_o` is 1 for that frame. A frame that is loaded sets `underrun_o` back to 0.
- R8: The engine runs only while both `cfg_tx_en` and `cfg_if_en` are 1. Otherwise `bclk_o` is 1, `ws_o` is 0, `sd_o` is 0 and `s_ready` is 0.
- R9: With `cfg_loop`=1, `rx_sd_o` equals `sd_o`. With `cfg_loop`=0, `rx_sd_o` equals `rx_sd_i`.
- R10: With `cfg_master`=0, the block shifts on falling edges of `sck_in`. A change of `ws_in` restarts the slot count for the side that `ws_in` names. A change of `ws_in` to 0 is a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: follow `sck_in`/`ws_in` |
| cfg_align | input | 2 | Justification format code |
| cfg_slot_m1 | input | 5 | Slot width minus one |
| cfg_size_m1 | input | 5 | Sample size minus one |
| cfg_lanes_m1 | input | 2 | Active lane count minus one |
| cfg_chans_m1 | input | 3 | Active channel count minus one |
| cfg_loop | input | 1 | Internal loopback enable |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_if_en | input | 1 | Interface enable |
| cfg_div_m1 | input | DIV_W | Bit-clock half period in clocks, minus one |
| s_valid | input | 1 | Frame valid |
| s_data | input | 2·NUM_LANES·32 | One frame, 32 bits per channel |
| s_ready | output | 1 | Frame accepted this clock |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | NUM_LANES | Serial data, one bit per lane |
| rx_sd_i | input | NUM_LANES | Serial data from the pins for the receiver |
| rx_sd_o | output | NUM_LANES | Serial data delivered to the receiver |
| underrun_o | output | 1 | Current frame was zero-filled |

## Verification
In master mode, each data bit and word-select value is registered on the clock edge where `bclk_o` falls. The first fall comes `cfg_div_m1`+1 clocks after both enables are set. In slave mode, outputs update three clocks after the `sck_in` fall: two synchroniser stages plus the edge register. `s_ready` is high in the single clock before the frame-start edge, and `underrun_o` is registered on that same edge. Because of these delays, the bench compares every output at the next rising bit-clock edge, sampled on the falling system clock. By then every register on the path has settled. The bench also times the gap between rising edges to check the divider period.

// File: rtl/i2s_mlane_pkg.sv
package i2s_mlane_pkg;

    localparam int SLOT_MAX = 32;
    localparam int POS_W    = $clog2(SLOT_MAX);

    typedef enum logic [1:0] {
        ALIGN_STD   = 2'd0,
        ALIGN_LEFT  = 2'd1,
        ALIGN_RIGHT = 2'd2,
        ALIGN_RSVD  = 2'd3
    } align_e;

    // Format and population settings consumed by every lane
    typedef struct packed {
        align_e           align;
        logic [POS_W-1:0] slot_m1;
        logic [POS_W-1:0] size_m1;
        logic [1:0]       lanes_m1;
        logic [2:0]       chans_m1;
    } fmt_cfg_t;

    // Position of the bit clock inside a slot pair
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             side;
    } slot_pos_t;

    // Bit sent at slot position pos for a sample, left- or right-justified
    function automatic logic slot_bit(input logic [SLOT_MAX-1:0] smp,
                                      input logic [POS_W-1:0]    pos,
                                      input logic [POS_W-1:0]    slot_m1,
                                      input logic [POS_W-1:0]    size_m1,
                                      input logic                rjust);
        int   w;
        int   s;
        int   p;
        int   k;
        logic r;
        w = int'(slot_m1) + 1;
        s = int'(size_m1) + 1;
        p = int'(pos);
        r = 1'b0;
        if (p < w) begin
            if (rjust) begin
                if (p >= w - s) begin
                    k = w - 1 - p;
                    r = smp[POS_W'(k)];
                end
            end else begin
                if (p < s) begin
                    k = s - 1 - p;
                    r = smp[POS_W'(k)];
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/i2s_mlane_clkgen.sv
module i2s_mlane_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             master,
    input  logic [DIV_W-1:0] div_m1,
    input  logic             sck_in,
    input  logic             ws_in,
    output logic             tick,
    output logic             bclk,
    output logic             ws_ext
);

    logic [DIV_W-1:0] cnt;
    logic             bclk_q;
    logic             sck_s1, sck_s2, sck_q;
    logic             ws_s1, ws_s2;
    logic             div_hit;

    assign div_hit = (cnt == div_m1);

    // Master divider: bit clock idles high, first toggle is a falling edge
    always_ff @(posedge clk) begin
        if (rst || !run || !master) begin
            cnt    <= '0;
            bclk_q <= 1'b1;
        end else if (div_hit) begin
            cnt    <= '0;
            bclk_q <= ~bclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Slave inputs: two-stage synchroniser plus edge register
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s1 <= 1'b1;
            sck_s2 <= 1'b1;
            sck_q  <= 1'b1;
            ws_s1  <= 1'b1;
            ws_s2  <= 1'b1;
        end else begin
            sck_s1 <= sck_in;
            sck_s2 <= sck_s1;
            sck_q  <= sck_s2;
            ws_s1  <= ws_in;
            ws_s2  <= ws_s1;
        end
    end

    always_comb begin
        if (!run)        tick = 1'b0;
        else if (master) tick = div_hit && bclk_q;
        else             tick = sck_q && !sck_s2;
    end

    assign bclk   = bclk_q;
    assign ws_ext = ws_s2;

    // R2: between divider hits the bit clock holds its level
    assert_div_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (run && master && !div_hit) |=> ($stable(bclk_q) || !run || !master));

    // R6: shift events never fall on two adjacent clocks
    assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/i2s_mlane_framer.sv
module i2s_mlane_framer import i2s_mlane_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             master,
    input  logic             tick,
    input  logic             ws_ext,
    input  logic [POS_W-1:0] slot_m1,
    output slot_pos_t        cur,
    output slot_pos_t        nxt,
    output logic             frame_start
);

    slot_pos_t st;
    logic      wrap;

    assign wrap = (st.pos >= slot_m1);

    always_comb begin
        nxt = st;
        if (master) begin
            nxt.pos  = wrap ? '0 : st.pos + 1'b1;
            nxt.side = wrap ? ~st.side : st.side;
        end else if (ws_ext != st.side) begin
            nxt.pos  = '0;
            nxt.side = ws_ext;
        end else begin
            nxt.pos  = (&st.pos) ? st.pos : st.pos + 1'b1;
            nxt.side = st.side;
        end
    end

    assign frame_start = tick && st.side && !nxt.side;
    assign cur         = st;

    // Idle parks at the last right-slot bit so the first shift opens a frame
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st.pos  <= slot_m1;
            st.side <= 1'b1;
        end else if (tick) begin
            st <= nxt;
        end
    end

    // R6: a frame start leaves the engine at left slot, bit zero
    assert_frame_origin_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (st.pos == '0 && !st.side));

    // R3: in master mode a slot ends after slot_m1+1 bits
    assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && master && st.pos == slot_m1) |=> (st.pos == '0));

endmodule

// File: rtl/i2s_mlane_lane.sv
module i2s_mlane_lane import i2s_mlane_pkg::*; #(
    parameter int LANE_IDX = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                tick,
    input  logic                frame_start,
    input  logic                load_ok,
    input  fmt_cfg_t            fmt,
    input  logic [SLOT_MAX-1:0] smp_l,
    input  logic [SLOT_MAX-1:0] smp_r,
    input  slot_pos_t           cur,
    input  slot_pos_t           nxt,
    output logic                sd
);

    localparam logic [1:0] LANE_ID = 2'(LANE_IDX);
    localparam logic [2:0] CH_L    = 3'(2 * LANE_IDX);
    localparam logic [2:0] CH_R    = 3'(2 * LANE_IDX + 1);

    logic                on_l, on_r;
    logic [SLOT_MAX-1:0] hold_l, hold_r;
    logic [SLOT_MAX-1:0] next_l, next_r;
    logic [SLOT_MAX-1:0] smp_now, smp_nxt;
    logic                bit_std, bit_left, bit_right, sd_d;

    assign on_l = (LANE_ID <= fmt.lanes_m1) && (CH_L <= fmt.chans_m1);
    assign on_r = (LANE_ID <= fmt.lanes_m1) && (CH_R <= fmt.chans_m1);

    always_comb begin
        next_l = hold_l;
        next_r = hold_r;
        if (frame_start) begin
            next_l = (load_ok && on_l) ? smp_l : '0;
            next_r = (load_ok && on_r) ? smp_r : '0;
        end
    end

    assign smp_now = cur.side ? hold_r : hold_l;
    assign smp_nxt = nxt.side ? next_r : next_l;

    // Standard format is the left-justified stream one bit clock late
    always_comb begin
        bit_std   = slot_bit(smp_now, cur.pos, fmt.slot_m1, fmt.size_m1, 1'b0);
        bit_left  = slot_bit(smp_nxt, nxt.pos, fmt.slot_m1, fmt.size_m1, 1'b0);
        bit_right = slot_bit(smp_nxt, nxt.pos, fmt.slot_m1, fmt.size_m1, 1'b1);
        case (fmt.align)
            ALIGN_STD:   sd_d = bit_std;
            ALIGN_RIGHT: sd_d = bit_right;
            default:     sd_d = bit_left;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hold_l <= '0;
            hold_r <= '0;
            sd     <= 1'b0;
        end else if (tick) begin
            hold_l <= next_l;
            hold_r <= next_r;
            sd     <= sd_d;
        end
    end

    // R7: a frame start without data clears the held pair
    assert_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !load_ok) |=> (hold_l == '0 && hold_r == '0));

    // R4: a disabled channel never holds sample data after a frame start
    assert_chan_off_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !on_l && !on_r) |=> (hold_l == '0 && hold_r == '0));

endmodule

// File: rtl/i2s_mlane_tx.sv
module i2s_mlane_tx import i2s_mlane_pkg::*; #(
    parameter int NUM_LANES = 4,
    parameter int DIV_W     = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_master,
    input  logic [1:0]                      cfg_align,
    input  logic [4:0]                      cfg_slot_m1,
    input  logic [4:0]                      cfg_size_m1,
    input  logic [1:0]                      cfg_lanes_m1,
    input  logic [2:0]                      cfg_chans_m1,
    input  logic                            cfg_loop,
    input  logic                            cfg_tx_en,
    input  logic                            cfg_if_en,
    input  logic [DIV_W-1:0]                cfg_div_m1,
    input  logic                            s_valid,
    input  logic [2*NUM_LANES*SLOT_MAX-1:0] s_data,
    output logic                            s_ready,
    input  logic                            sck_in,
    input  logic                            ws_in,
    output logic                            bclk_o,
    output logic                            ws_o,
    output logic [NUM_LANES-1:0]            sd_o,
    input  logic [NUM_LANES-1:0]            rx_sd_i,
    output logic [NUM_LANES-1:0]            rx_sd_o,
    output logic                            underrun_o
);

    localparam int FRAME_W = 2 * SLOT_MAX;

    logic      run, tick, ws_ext, frame_start;
    logic      ws_q, underrun_q;
    slot_pos_t cur_pos, nxt_pos;
    fmt_cfg_t  fmt;
    logic [NUM_LANES-1:0] sd_w;

    assign run = cfg_tx_en & cfg_if_en;

    assign fmt = '{align:    align_e'(cfg_align),
                   slot_m1:  cfg_slot_m1,
                   size_m1:  cfg_size_m1,
                   lanes_m1: cfg_lanes_m1,
                   chans_m1: cfg_chans_m1};

    i2s_mlane_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .master (cfg_master),
        .div_m1 (cfg_div_m1),
        .sck_in (sck_in),
        .ws_in  (ws_in),
        .tick   (tick),
        .bclk   (bclk_o),
        .ws_ext (ws_ext)
    );

    i2s_mlane_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .master      (cfg_master),
        .tick        (tick),
        .ws_ext      (ws_ext),
        .slot_m1     (cfg_slot_m1),
        .cur         (cur_pos),
        .nxt         (nxt_pos),
        .frame_start (frame_start)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        i2s_mlane_lane #(.LANE_IDX(g)) u_lane (
            .clk         (clk),
            .rst         (rst),
            .run         (run),
            .tick        (tick),
            .frame_start (frame_start),
            .load_ok     (s_valid),
            .fmt         (fmt),
            .smp_l       (s_data[g*FRAME_W +: SLOT_MAX]),
            .smp_r       (s_data[g*FRAME_W + SLOT_MAX +: SLOT_MAX]),
            .cur         (cur_pos),
            .nxt         (nxt_pos),
            .sd          (sd_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ws_q       <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            if (tick)        ws_q       <= nxt_pos.side;
            if (frame_start) underrun_q <= !s_valid;
        end
    end

    assign s_ready    = frame_start;
    assign ws_o       = ws_q;
    assign underrun_o = underrun_q;
    assign sd_o       = sd_w;
    assign rx_sd_o    = cfg_loop ? sd_w : rx_sd_i;

    // R7: a missed frame start raises the underrun flag
    assert_underrun_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !s_valid) |=> underrun_o);

    // R8: a stopped engine leaves every lane low
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sd_o == '0 && !ws_o));

    // R6: a ready pulse lasts a single clock
    assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> !s_ready);

endmodule

// File: tb/i2s_mlane_tx_tb.sv
module i2s_mlane_tx_tb;

    localparam int NL = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst = 1'b1;
    logic         cfg_master = 1'b1;
    logic [1:0]   cfg_align = 2'd1;
    logic [4:0]   cfg_slot_m1 = 5'd31, cfg_size_m1 = 5'd31;
    logic [1:0]   cfg_lanes_m1 = 2'd0;
    logic [2:0]   cfg_chans_m1 = 3'd1;
    logic         cfg_loop = 1'b0, cfg_tx_en = 1'b0, cfg_if_en = 1'b0;
    logic [7:0]   cfg_div_m1 = 8'd1;
    logic         s_valid = 1'b0;
    logic [255:0] s_data = '0;
    logic         s_ready;
    logic         sck_in = 1'b1, ws_in = 1'b1;
    logic         bclk_o, ws_o, underrun_o;
    logic [NL-1:0] sd_o, rx_sd_o;
    logic [NL-1:0] rx_sd_i = 4'b0110;

    i2s_mlane_tx u_dut (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_align(cfg_align),
        .cfg_slot_m1(cfg_slot_m1), .cfg_size_m1(cfg_size_m1),
        .cfg_lanes_m1(cfg_lanes_m1), .cfg_chans_m1(cfg_chans_m1),
        .cfg_loop(cfg_loop), .cfg_tx_en(cfg_tx_en), .cfg_if_en(cfg_if_en),
        .cfg_div_m1(cfg_div_m1), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .sck_in(sck_in), .ws_in(ws_in), .bclk_o(bclk_o),
        .ws_o(ws_o), .sd_o(sd_o), .rx_sd_i(rx_sd_i), .rx_sd_o(rx_sd_o),
        .underrun_o(underrun_o)
    );

    int n_tests = 0, n_fail = 0;
    bit ended = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_tb();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Scoreboard state
    logic [255:0] exp_q[$];
    logic [255:0] cur_frame = '0;
    logic [3:0]   prev_lj = '0;
    bit           mon_on = 0;
    bit           mclk_prev = 1'b1;
    int           k_cnt = 0, cyc = 0, last_rise = 0, ready_cnt = 0;
    string        tag = "R1";

    task automatic check_rise();
        int w, s, fp, pos;
        bit side;
        logic [3:0] lj, rj, exp_sd, exp_rx;
        w = int'(cfg_slot_m1) + 1;
        s = int'(cfg_size_m1) + 1;
        fp = k_cnt % (2 * w);
        side = (fp >= w);
        pos = fp % w;
        if (fp == 0) begin
            bit miss;
            miss = (exp_q.size() == 0);
            cur_frame = miss ? '0 : exp_q.pop_front();
            chk(underrun_o == miss, "R7", "underrun flag at frame start", 64'(underrun_o), 64'(miss));
        end
        for (int l = 0; l < NL; l++) begin
            int ch;
            logic [31:0] smp;
            ch = 2 * l + int'(side);
            smp = (l <= int'(cfg_lanes_m1) && ch <= int'(cfg_chans_m1)) ? cur_frame[ch*32 +: 32] : 32'd0;
            lj[l] = (pos < s) ? smp[s-1-pos] : 1'b0;
            rj[l] = (pos >= w - s) ? smp[w-1-pos] : 1'b0;
        end
        exp_sd = (cfg_align == 2'd0) ? prev_lj : (cfg_align == 2'd2) ? rj : lj;
        chk(sd_o == exp_sd && ws_o == side, tag, $sformatf("bit %0d {ws,sd}", k_cnt),
            64'({ws_o, sd_o}), 64'({side, exp_sd}));
        exp_rx = cfg_loop ? exp_sd : rx_sd_i;
        chk(rx_sd_o == exp_rx, "R9", "receive path", 64'(rx_sd_o), 64'(exp_rx));
        if (cfg_master && k_cnt > 0)
            chk(cyc - last_rise == 2 * (int'(cfg_div_m1) + 1), "R2", "bit clock period",
                64'(cyc - last_rise), 64'(2 * (int'(cfg_div_m1) + 1)));
        last_rise = cyc;
        prev_lj = lj;
        k_cnt++;
    endtask

    // Monitor: compares at each rising bit-clock edge, sampled on falling clk
    always @(negedge clk) begin
        logic mclk_now;
        cyc++;
        if (s_ready) ready_cnt++;
        mclk_now = cfg_master ? bclk_o : sck_in;
        if (mon_on && mclk_now && !mclk_prev) check_rise();
        mclk_prev = mclk_now;
    end

    // Driver: offers a frame and records it once accepted
    task automatic send_frame(input logic [255:0] d);
        s_data = d;
        s_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (s_ready) break;
        end
        @(posedge clk);
        #1;
        exp_q.push_back(d);
    endtask

    function automatic logic [255:0] rnd_frame();
        logic [255:0] d;
        for (int i = 0; i < 8; i++) d[i*32 +: 32] = $urandom;
        return d;
    endfunction

    task automatic arm(input string t);
        exp_q.delete();
        k_cnt = 0;
        prev_lj = '0;
        ready_cnt = 0;
        tag = t;
        mon_on = 1;
    endtask

    task automatic run_master(input logic [1:0] al, input logic [4:0] sl, input logic [4:0] sz,
                              input logic [1:0] ln, input logic [2:0] ch, input logic [7:0] dv,
                              input int nfr, input int extra, input string t);
        int target;
        @(negedge clk);
        cfg_master = 1'b1; cfg_align = al; cfg_slot_m1 = sl; cfg_size_m1 = sz;
        cfg_lanes_m1 = ln; cfg_chans_m1 = ch; cfg_div_m1 = dv;
        arm(t);
        cfg_tx_en = 1'b1; cfg_if_en = 1'b1;
        for (int i = 0; i < nfr; i++) send_frame(rnd_frame());
        s_valid = 1'b0;
        target = (nfr + extra) * 2 * (int'(sl) + 1);
        wait (k_cnt >= target);
        mon_on = 0;
        cfg_tx_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic slave_pulse(input logic w);
        @(posedge clk);
        sck_in <= 1'b0;
        ws_in  <= w;
        repeat (4) @(posedge clk);
        sck_in <= 1'b1;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_tb();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk(bclk_o == 1 && ws_o == 0 && sd_o == 0 && !s_ready && !underrun_o, "R8",
            "reset state {bclk,ws,sd,ready,ur}", 64'({bclk_o, ws_o, sd_o, s_ready, underrun_o}),
            64'({1'b1, 1'b0, 4'b0, 1'b0, 1'b0}));

        // R1/R6: left-justified, full 32-bit slot, one stereo lane
        run_master(2'd1, 5'd31, 5'd31, 2'd0, 3'd1, 8'd1, 3, 0, "R1");
        chk(ready_cnt == 3, "R6", "ready pulses per frame", 64'(ready_cnt), 64'd3);

        // R1/R3: standard format, 24-bit samples in 32-bit slots, two lanes
        run_master(2'd0, 5'd31, 5'd23, 2'd1, 3'd3, 8'd2, 3, 0, "R3");

        // R1/R4/R9: right-justified 16 in 32, four lanes, loopback
        cfg_loop = 1'b1;
        run_master(2'd2, 5'd31, 5'd15, 2'd3, 3'd7, 8'd1, 2, 0, "R4");
        cfg_loop = 1'b0;

        // R4: five channels over four lanes, upper channels silent
        run_master(2'd1, 5'd15, 5'd15, 2'd3, 3'd4, 8'd1, 2, 0, "R4");

        // R5: mono, standard format, 16-bit slots
        run_master(2'd0, 5'd15, 5'd15, 2'd0, 3'd0, 8'd1, 2, 0, "R5");

        // R7: one frame then two starved frames
        run_master(2'd1, 5'd15, 5'd15, 2'd1, 3'd3, 8'd1, 1, 2, "R7");

        // R8: only one enable set, engine stays quiet
        for (int m = 0; m < 2; m++) begin
            bit moved;
            moved = 0;
            @(negedge clk);
            cfg_tx_en = (m == 0);
            cfg_if_en = (m == 1);
            s_valid = 1'b1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (bclk_o != 1 || ws_o != 0 || sd_o != 0 || s_ready) moved = 1;
            end
            chk(!moved, "R8", "single enable kept engine idle", 64'(moved), 64'd0);
            cfg_tx_en = 1'b0; cfg_if_en = 1'b0; s_valid = 1'b0;
        end

        // R10: slave mode, external clock and word select, 16-bit left-justified
        @(negedge clk);
        cfg_master = 1'b0; cfg_align = 2'd1; cfg_slot_m1 = 5'd15; cfg_size_m1 = 5'd15;
        cfg_lanes_m1 = 2'd0; cfg_chans_m1 = 3'd1;
        cfg_tx_en = 1'b1; cfg_if_en = 1'b1;
        repeat (3) slave_pulse(1'b1);
        @(negedge clk);
        arm("R10");
        fork
            begin
                for (int i = 0; i < 2; i++) send_frame(rnd_frame());
                s_valid = 1'b0;
            end
            begin
                for (int k = 0; k < 2 * 32; k++) slave_pulse((k % 32) >= 16);
                @(negedge clk);
                mon_on = 0;
            end
        join
        chk(k_cnt == 64, "R10", "slave bits compared", 64'(k_cnt), 64'd64);
        cfg_tx_en = 1'b0;
        repeat (4) @(negedge clk);

        finish_tb();
    end

endmodule